// File: doc/BRIEF.md
# Bidirectional Latch-Register Bus Transceiver

This block carries a data word between two ports, A and B, in both directions at once. Each direction has its own storage path that can pass data straight through, hold the last word, or capture a new word on a rising edge of that direction's own strobe. A per-direction clock enable gates that capture. Each direction has four controls: a pass enable, a capture strobe, an active-low strobe enable and an active-low output enable.

The ports are split into separate input, output and output-enable signals, so the block contains no tri-state logic. A pad wrapper can merge each triple into a real inout pin. The pass path is a combinational multiplexer in front of a flop. Edge capture is done by sampling the strobe on a core clock `clk`. This keeps the block free of latches and of extra clock domains. Each direction strobe is expected to be synchronous to `clk`.

Top module: `xcvr_bidir`

## Requirements
- R1: A synchronous active-high `rst` clears both stored words to zero. After reset, with the pass enables low and the output enables asserted, `b_o` and `a_o` read 0.
- R2: While a direction's pass enable (`ab_pass` / `ba_pass`) is 1, its output equals its input in the same cycle, whatever the strobe does.
- R3: When a pass enable falls from 1 to 0, the output keeps the input value sampled at the last `clk` edge where the pass enable was still 1.
- R4: While the pass enable is 0 and no capture occurs, the output stays constant even when the input changes.
- R5: With the pass enable 0 and `*_stb_en_n` at 0, a rising strobe captures the input at the first `clk` edge that sees the strobe at 1. A rising strobe means the level was 0 at one `clk` edge and 1 at the next. The captured value appears on the output immediately after that edge.
- R6: While `*_stb_en_n` is 1, a rising strobe is ignored and the stored word is unchanged.
- R7: The port output-enable `b_oe` / `a_oe` is 1 exactly when `ab_oe_n` / `ba_oe_n` is 0. Toggling the output enable does not change the data presented.
- R8: Passing or capturing in one direction never changes the word stored or presented in the other direction.
- R9: A strobe held at 1, or a falling strobe, captures nothing. Only one capture happens per rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock that samples strobes and updates storage |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | W (18) | Word arriving at port A |
| a_o | output | W (18) | Word driven out of port A (B-to-A path) |
| a_oe | output | 1 | Port A drive enable, 1 = drive |
| b_i | input | W (18) | Word arriving at port B |
| b_o | output | W (18) | Word driven out of port B (A-to-B path) |
| b_oe | output | 1 | Port B drive enable, 1 = drive |
| ab_pass | input | 1 | A-to-B pass-through enable, 1 = transparent |
| ab_stb | input | 1 | A-to-B capture strobe |
| ab_stb_en_n | input | 1 | A-to-B strobe enable, 0 = strobe active |
| ab_oe_n | input | 1 | A-to-B output enable, 0 = drive port B |
| ba_pass | input | 1 | B-to-A pass-through enable, 1 = transparent |
| ba_stb | input | 1 | B-to-A capture strobe |
| ba_stb_en_n | input | 1 | B-to-A strobe enable, 0 = strobe active |
| ba_oe_n | input | 1 | B-to-A output enable, 0 = drive port A |

## Verification
A corrupted stored word shows up on the output port in the first cycle the pass enable is low. A missed or doubled capture shows up one `clk` edge after the strobe rises. Because of this, every hold, capture and strobe-gating case is checked on the output right after that edge. A fault in the edge history shows up as a capture while the strobe stays high or falls, so those cases are checked with the input changed beforehand. Cross-talk between directions can only be seen on the idle direction's output, so it is read after each operation on the other direction.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    parameter int XCVR_W    = 18;
    parameter int NUM_LANES = 2;

    localparam int LANE_AB = 0;
    localparam int LANE_BA = 1;

    // Control bundle for one direction
    typedef struct packed {
        logic pass;
        logic stb;
        logic stb_en_n;
        logic oe_n;
    } lane_ctrl_t;

    // What the storage does on the coming clk edge
    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_PASS    = 2'd1,
        OP_CAPTURE = 2'd2
    } lane_op_t;

    // Pass enable outranks the strobe; gated rising edge captures
    function automatic lane_op_t decode_op(input logic pass,
                                           input logic rise,
                                           input logic stb_en_n);
        if (pass)
            return OP_PASS;
        else if (rise && !stb_en_n)
            return OP_CAPTURE;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge (
    input  logic clk,
    input  logic level,
    output logic rise
);
    logic hist;

    always_ff @(posedge clk) begin
        hist <= level;
    end

    assign rise = level & ~hist;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
    import xcvr_pkg::*;
#(
    parameter int W = XCVR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  lane_op_t     op,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            case (op)
                OP_PASS:    q <= din;
                OP_CAPTURE: q <= din;
                default:    q <= q;
            endcase
        end
    end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = XCVR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  lane_ctrl_t   ctrl,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         oe
);
    logic         rise;
    lane_op_t     op;
    logic [W-1:0] held;

    xcvr_edge u_edge (
        .clk   (clk),
        .level (ctrl.stb),
        .rise  (rise)
    );

    assign op = decode_op(ctrl.pass, rise, ctrl.stb_en_n);

    xcvr_store #(.W(W)) u_store (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .din (din),
        .q   (held)
    );

    // Transparent path bypasses storage in the same cycle
    assign dout = ctrl.pass ? din : held;
    assign oe   = ~ctrl.oe_n;
endmodule

// File: rtl/xcvr_bidir.sv
module xcvr_bidir
    import xcvr_pkg::*;
#(
    parameter int W = XCVR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_i,
    output logic [W-1:0] a_o,
    output logic         a_oe,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] b_o,
    output logic         b_oe,
    input  logic         ab_pass,
    input  logic         ab_stb,
    input  logic         ab_stb_en_n,
    input  logic         ab_oe_n,
    input  logic         ba_pass,
    input  logic         ba_stb,
    input  logic         ba_stb_en_n,
    input  logic         ba_oe_n
);
    lane_ctrl_t   ctrl [NUM_LANES];
    logic [W-1:0] din  [NUM_LANES];
    logic [W-1:0] dout [NUM_LANES];
    logic         oe   [NUM_LANES];

    assign ctrl[LANE_AB] = '{pass: ab_pass, stb: ab_stb, stb_en_n: ab_stb_en_n, oe_n: ab_oe_n};
    assign ctrl[LANE_BA] = '{pass: ba_pass, stb: ba_stb, stb_en_n: ba_stb_en_n, oe_n: ba_oe_n};
    assign din[LANE_AB]  = a_i;
    assign din[LANE_BA]  = b_i;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        xcvr_lane #(.W(W)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .ctrl (ctrl[g]),
            .din  (din[g]),
            .dout (dout[g]),
            .oe   (oe[g])
        );
    end

    assign b_o  = dout[LANE_AB];
    assign b_oe = oe[LANE_AB];
    assign a_o  = dout[LANE_BA];
    assign a_oe = oe[LANE_BA];
endmodule

// File: rtl/xcvr_bidir_chk.sv
module xcvr_bidir_chk #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_i,
    input logic [W-1:0] a_o,
    input logic [W-1:0] b_i,
    input logic [W-1:0] b_o,
    input logic         ab_pass,
    input logic         ab_stb,
    input logic         ab_stb_en_n,
    input logic         ba_pass,
    input logic         ba_stb,
    input logic         ba_stb_en_n
);
    // R3: closing the pass path keeps the word sampled on the last open edge
    p_close_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        (!ab_pass && $past(ab_pass) && !$past(rst)) |-> (b_o == $past(a_i)));

    // R4/R9: no rising gated strobe last edge -> A-to-B output steady
    p_hold_ab_r4: assert property (@(posedge clk) disable iff (rst)
        (!ab_pass && !$past(ab_pass) && !$past(rst)
         && !($past(ab_stb) && !$past(ab_stb, 2) && !$past(ab_stb_en_n)))
        |-> (b_o == $past(b_o)));

    // R8: B-to-A output steady regardless of A-to-B activity
    p_hold_ba_r8: assert property (@(posedge clk) disable iff (rst)
        (!ba_pass && !$past(ba_pass) && !$past(rst)
         && !($past(ba_stb) && !$past(ba_stb, 2) && !$past(ba_stb_en_n)))
        |-> (a_o == $past(a_o)));

    // R5: gated rising strobe captures the input of that edge
    p_capture_ab_r5: assert property (@(posedge clk) disable iff (rst)
        (!ab_pass && !$past(ab_pass) && !$past(rst)
         && $past(ab_stb) && !$past(ab_stb, 2) && !$past(ab_stb_en_n))
        |-> (b_o == $past(a_i)));

    p_capture_ba_r5: assert property (@(posedge clk) disable iff (rst)
        (!ba_pass && !$past(ba_pass) && !$past(rst)
         && $past(ba_stb) && !$past(ba_stb, 2) && !$past(ba_stb_en_n))
        |-> (a_o == $past(b_i)));

    // R6: disabled strobe leaves the word alone
    p_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (!ab_pass && !$past(ab_pass) && !$past(rst) && $past(ab_stb_en_n))
        |-> (b_o == $past(b_o)));
endmodule

bind xcvr_bidir xcvr_bidir_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .a_i         (a_i),
    .a_o         (a_o),
    .b_i         (b_i),
    .b_o         (b_o),
    .ab_pass     (ab_pass),
    .ab_stb      (ab_stb),
    .ab_stb_en_n (ab_stb_en_n),
    .ba_pass     (ba_pass),
    .ba_stb      (ba_stb),
    .ba_stb_en_n (ba_stb_en_n)
);

// File: tb/sim_xcvr_bidir.sv
`timescale 1ns/1ps
module sim_xcvr_bidir;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_i, b_i, a_o, b_o;
    logic         a_oe, b_oe;
    logic         ab_pass, ab_stb, ab_stb_en_n, ab_oe_n;
    logic         ba_pass, ba_stb, ba_stb_en_n, ba_oe_n;

    int errs  = 0;
    int total = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    xcvr_bidir #(.W(W)) u0 (
        .clk(clk), .rst(rst),
        .a_i(a_i), .a_o(a_o), .a_oe(a_oe),
        .b_i(b_i), .b_o(b_o), .b_oe(b_oe),
        .ab_pass(ab_pass), .ab_stb(ab_stb), .ab_stb_en_n(ab_stb_en_n), .ab_oe_n(ab_oe_n),
        .ba_pass(ba_pass), .ba_stb(ba_stb), .ba_stb_en_n(ba_stb_en_n), .ba_oe_n(ba_oe_n)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Capture one word into A-to-B via a clean rising strobe
    task automatic load_ab(input logic [W-1:0] v);
        ab_pass = 1'b0; ab_stb_en_n = 1'b0; ab_stb = 1'b0;
        tick();
        a_i = v; ab_stb = 1'b1;
        tick();
        ab_stb = 1'b0;
        tick();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        a_i = '0; b_i = '0;
        ab_pass = 1'b0; ab_stb = 1'b0; ab_stb_en_n = 1'b1; ab_oe_n = 1'b0;
        ba_pass = 1'b0; ba_stb = 1'b0; ba_stb_en_n = 1'b1; ba_oe_n = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check("R1 b_o after reset", b_o, '0);
        check("R1 a_o after reset", a_o, '0);
    endtask

    task automatic t_pass();
        ab_pass = 1'b1;
        a_i = 18'h2A5A5; #1;
        check("R2 pass same cycle", b_o, 18'h2A5A5);
        a_i = 18'h15A5A; ab_stb = 1'b1; #1;
        check("R2 pass ignores strobe", b_o, 18'h15A5A);
        tick();
        ab_stb = 1'b0;
        tick();
    endtask

    task automatic t_close();
        ab_pass = 1'b1; a_i = 18'h0F0F0;
        tick();
        ab_pass = 1'b0; a_i = 18'h30303; #1;
        check("R3 close keeps last passed", b_o, 18'h0F0F0);
        tick();
        check("R3 close still kept", b_o, 18'h0F0F0);
    endtask

    task automatic t_hold();
        ab_pass = 1'b0; ab_stb = 1'b0; ab_stb_en_n = 1'b0;
        a_i = 18'h3FFFF;
        tick();
        a_i = 18'h00001;
        tick();
        check("R4 hold with strobe low", b_o, 18'h0F0F0);
    endtask

    task automatic t_capture();
        ab_pass = 1'b0; ab_stb_en_n = 1'b0; ab_stb = 1'b0;
        tick();
        a_i = 18'h12345; ab_stb = 1'b1; #1;
        check("R5 before capture edge", b_o, 18'h0F0F0);
        tick();
        check("R5 captured after edge", b_o, 18'h12345);
    endtask

    task automatic t_no_recapture();
        a_i = 18'h2BCDE;      // strobe still high
        repeat (2) tick();
        check("R9 strobe held high", b_o, 18'h12345);
        ab_stb = 1'b0;
        tick();
        check("R9 falling strobe", b_o, 18'h12345);
    endtask

    task automatic t_gate();
        ab_stb_en_n = 1'b1; a_i = 18'h0AAAA; ab_stb = 1'b1;
        tick();
        check("R6 gated strobe ignored", b_o, 18'h12345);
        ab_stb = 1'b0;
        tick();
        ab_stb_en_n = 1'b0;
        tick();
        check("R6 re-enable alone no capture", b_o, 18'h12345);
    endtask

    task automatic t_oe();
        ab_oe_n = 1'b1; #1;
        check("R7 b_oe off", {17'd0, b_oe}, 18'd0);
        check("R7 data unchanged when off", b_o, 18'h12345);
        ab_oe_n = 1'b0; ba_oe_n = 1'b1; #1;
        check("R7 b_oe on", {17'd0, b_oe}, 18'd1);
        check("R7 a_oe off", {17'd0, a_oe}, 18'd0);
        ba_oe_n = 1'b0; #1;
        check("R7 a_oe on", {17'd0, a_oe}, 18'd1);
    endtask

    task automatic t_indep();
        ba_pass = 1'b0; ba_stb_en_n = 1'b0; ba_stb = 1'b0;
        tick();
        b_i = 18'h1C3C3; ba_stb = 1'b1;
        tick();
        ba_stb = 1'b0;
        check("R8 B-to-A captured", a_o, 18'h1C3C3);
        check("R8 A-to-B untouched by B-to-A", b_o, 18'h12345);
        load_ab(18'h26969);
        check("R8 A-to-B new capture", b_o, 18'h26969);
        check("R8 B-to-A untouched by capture", a_o, 18'h1C3C3);
        ab_pass = 1'b1; a_i = 18'h00FFF;
        tick();
        ab_pass = 1'b0;
        tick();
        check("R8 B-to-A untouched by pass", a_o, 18'h1C3C3);
        b_i = 18'h3E1E1; ba_pass = 1'b1; #1;
        check("R2 B-to-A pass", a_o, 18'h3E1E1);
        check("R8 A-to-B untouched by B pass", b_o, 18'h00FFF);
        tick();
        ba_pass = 1'b0;
        tick();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_pass();
        t_close();
        t_hold();
        t_capture();
        t_no_recapture();
        t_gate();
        t_oe();
        t_indep();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, total);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            errs++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, total);
            $finish;
        end
    end
endmodule